// File: doc/BRIEF.md
# Parallel NOR Sector Erase Sequencer

This block erases a range of sectors in a parallel NOR flash through a simple bus master port. A one-cycle start pulse carries a first and a last sector index. The block then walks the range one sector at a time. It skips any sector marked in the protect bitmap. For each sector it does erase, it writes the command sequence of the selected command family, polls the device until it is no longer busy, and classifies the outcome.

Two command families are supported, chosen by `fam_sel` when the request is accepted. The status family reports completion in a status bit and gives detailed failure bits. The toggle family signals activity through a bit that changes value on every read while an operation runs.

Polling is bounded by a cycle budget. If the device is still busy when the budget runs out, the block issues the family's reset command, records a timeout and moves on to the next sector. Each error flag stays set until the next accepted request.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_we`, `bus_re`, `err` and every error class output are 0.
- R2: With `fam_sel`=0 (status family), erasing a sector writes 0x50, then 0x20, then 0xD0, all at the sector's base byte address. Each command byte is driven on the top byte of every chip lane of `bus_wdata` (bits [CHIP_BYTES*8-1 -: 8] of each lane), and all other bytes are zero.
- R3: With `fam_sel`=1 (toggle family), erasing a sector writes 0xAA at word offset 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and finally 0x30 at the base. Each byte address is the base plus the word offset times PORT_BYTES.
- R4: A sector whose `protect_map` bit is 1 produces no write and no read strobe.
- R5: A request with `first_sect` > `last_sect` makes no bus access. It raises `done` with `err`=1 and all class bits 0.
- R6: In the status family, the device counts as busy while bit 7 of the status byte is 0. The status byte is the top byte of each lane, and every lane must show bit 7 set. Polling keeps reading until this holds, so N busy reads are followed by exactly one more read.
- R7: In the toggle family, the device counts as busy until two consecutive status reads return the same bit 6. The first read of a sector always counts as busy.
- R8: If the device is still busy once `timeout_cycles` clock cycles of polling have elapsed, the block writes the reset command at the sector base. The reset command is 0xFF for the status family and 0xF0 for the toggle family. The block then sets `err_timeout` and `err`.
- R9: In the status family, a finished status is classified as follows: bits 5 and 4 both set gives `err_cmdseq`; bit 5 without bit 4 gives `err_erase`; bit 1 gives `err_locked`; bit 3 gives `err_vpp`. Any of bits 5, 4, 3 or 1 set also sets `err`.
- R10: In the status family, every sector that completes without a timeout ends with a 0xFF write at its base, which returns the device to read-array mode.
- R11: Sectors are processed in ascending order. A failing sector does not stop the range, and the error flags accumulate over it. `busy` stays high for the whole run, and `done` is a one-cycle pulse issued as `busy` falls.
- R12: `bus_we` and `bus_re` are never high together. Each read strobe lasts one cycle, and the read data is sampled two cycles after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| first_sect | input | $clog2(NSECT) | First sector index of the range |
| last_sect | input | $clog2(NSECT) | Last sector index of the range |
| protect_map | input | NSECT | 1 = sector is protected and skipped; held stable while busy |
| sect_base | input | NSECT*ADDR_W | Base byte address of each sector, sector i at bits [i*ADDR_W +: ADDR_W] |
| fam_sel | input | 1 | 0 = status family, 1 = toggle family |
| timeout_cycles | input | TO_W | Polling budget in clock cycles |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | PORT_BYTES*8 | Flash write data |
| bus_rdata | input | PORT_BYTES*8 | Flash read data, valid the cycle after a read strobe |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| busy | output | 1 | A range is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | At least one failure in the request |
| err_timeout | output | 1 | A sector exceeded its polling budget |
| err_cmdseq | output | 1 | Command-sequence failure seen |
| err_erase | output | 1 | Erase failure seen |
| err_locked | output | 1 | Locked sector reported |
| err_vpp | output | 1 | Programming-voltage fault reported |

## Verification
The bench drives a device model that can stay busy for a set number of reads or stay busy forever, and that can return a chosen final status byte. A scoreboard checks the exact write stream against the two command families, so a block that swapped family sequences, scaled word offsets wrongly or put the command on the wrong byte lane would show a mismatched write. Protected sectors in the middle of a range, an inverted range and a zero-busy device target the skip and reject paths; a design that touched the bus there would leave unexpected writes. Stuck devices in both families check that the correct reset command follows a timeout and that the remaining sectors are still erased. Status bytes with 0x30, 0x20, 0x10, 0x02 and 0x08 check that the error classes are separated by priority rather than read off single bits.

// File: rtl/nes_pkg.sv
package nes_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_WR, ST_RD0, ST_RD1, ST_RD2, ST_NEXT
  } st_e;

  typedef enum logic {
    FAM_STAT   = 1'b0,
    FAM_TOGGLE = 1'b1
  } fam_e;

  localparam logic [7:0] C_CLRSTAT  = 8'h50;
  localparam logic [7:0] C_ERASE_A  = 8'h20;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_RESET_A  = 8'hFF;
  localparam logic [7:0] C_KEY1     = 8'hAA;
  localparam logic [7:0] C_KEY2     = 8'h55;
  localparam logic [7:0] C_SETUP_B  = 8'h80;
  localparam logic [7:0] C_ERASE_B  = 8'h30;
  localparam logic [7:0] C_RESET_B  = 8'hF0;

  localparam logic [11:0] OFS_KEY1 = 12'h555;
  localparam logic [11:0] OFS_KEY2 = 12'h2AA;

  typedef struct packed {
    logic [11:0] ofs;
    logic [7:0]  cmd;
  } step_t;

  typedef struct packed {
    logic seq;
    logic ers;
    logic lck;
    logic vpp;
  } fault_t;

  // Command step table for one sector erase, per family
  function automatic step_t erase_step(fam_e f, logic [2:0] idx);
    step_t s;
    s = '{ofs: 12'h000, cmd: 8'h00};
    if (f == FAM_STAT) begin
      case (idx)
        3'd0:    s.cmd = C_CLRSTAT;
        3'd1:    s.cmd = C_ERASE_A;
        default: s.cmd = C_CONFIRM;
      endcase
    end else begin
      case (idx)
        3'd0, 3'd3: s = '{ofs: OFS_KEY1, cmd: C_KEY1};
        3'd1, 3'd4: s = '{ofs: OFS_KEY2, cmd: C_KEY2};
        3'd2:       s = '{ofs: OFS_KEY1, cmd: C_SETUP_B};
        default:    s = '{ofs: 12'h000,  cmd: C_ERASE_B};
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/nes_cmd_lanes.sv
module nes_cmd_lanes #(
  parameter int PORT_BYTES = 2,
  parameter int CHIP_BYTES = 2,
  localparam int NLANE = PORT_BYTES / CHIP_BYTES,
  localparam int LW    = CHIP_BYTES * 8
) (
  input  logic [7:0]              cmd,
  output logic [PORT_BYTES*8-1:0] word
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    if (CHIP_BYTES == 1) begin : g_narrow
      assign word[l*LW +: LW] = cmd;
    end else begin : g_wide
      assign word[l*LW +: LW] = {cmd, {(LW-8){1'b0}}};
    end
  end
endmodule

// File: rtl/nes_poll_eval.sv
module nes_poll_eval
  import nes_pkg::*;
#(
  parameter int PORT_BYTES = 2,
  parameter int CHIP_BYTES = 2,
  localparam int NLANE = PORT_BYTES / CHIP_BYTES,
  localparam int LW    = CHIP_BYTES * 8
) (
  input  fam_e                    fam,
  input  logic [PORT_BYTES*8-1:0] rdata,
  input  logic [NLANE-1:0]        prev_b6,
  input  logic                    prev_ok,
  output logic                    dev_busy,
  output logic                    fail,
  output fault_t                  fault,
  output logic [NLANE-1:0]        b6_now
);
  logic [NLANE-1:0] rdy7, s5, s4, s3, s1;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [7:0] sb;
    assign sb      = rdata[(l+1)*LW-1 -: 8];
    assign rdy7[l] = sb[7];
    assign b6_now[l] = sb[6];
    assign s5[l]   = sb[5];
    assign s4[l]   = sb[4];
    assign s3[l]   = sb[3];
    assign s1[l]   = sb[1];
  end

  always_comb begin
    if (fam == FAM_STAT) dev_busy = ~(&rdy7);
    else                 dev_busy = ~prev_ok | (b6_now != prev_b6);
    fault.seq = |(s5 & s4);
    fault.ers = |(s5 & ~s4);
    fault.lck = |s1;
    fault.vpp = |s3;
    fail      = |(s5 | s4 | s3 | s1);
  end
endmodule

// File: rtl/nes_cycle_timer.sv
module nes_cycle_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TO_W-1:0] value,
  input  logic            run,
  output logic            expired
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= value;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - TO_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int NSECT      = 8,
  parameter int ADDR_W     = 24,
  parameter int PORT_BYTES = 2,
  parameter int CHIP_BYTES = 2,
  parameter int TO_W       = 16,
  localparam int SW     = $clog2(NSECT),
  localparam int DW     = PORT_BYTES * 8,
  localparam int NLANE  = PORT_BYTES / CHIP_BYTES,
  localparam int OFS_SH = $clog2(PORT_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SW-1:0]           first_sect,
  input  logic [SW-1:0]           last_sect,
  input  logic [NSECT-1:0]        protect_map,
  input  logic [NSECT*ADDR_W-1:0] sect_base,
  input  logic                    fam_sel,
  input  logic [TO_W-1:0]         timeout_cycles,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DW-1:0]           bus_wdata,
  input  logic [DW-1:0]           bus_rdata,
  output logic                    bus_we,
  output logic                    bus_re,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    err_timeout,
  output logic                    err_cmdseq,
  output logic                    err_erase,
  output logic                    err_locked,
  output logic                    err_vpp
);
  st_e              st;
  fam_e             fam_q;
  logic [SW-1:0]    cur_q, last_q;
  logic [TO_W-1:0]  tmo_q;
  logic [2:0]       step_q;
  logic             prev_ok;
  logic [NLANE-1:0] prev_b6;

  step_t            stp;
  logic [2:0]       last_step;
  logic [ADDR_W-1:0] base, addr_sel;
  logic [7:0]       cmd_sel;
  logic [DW-1:0]    lane_word;
  logic             tmr_load, tmr_run, expired;
  logic             dev_busy, fail;
  fault_t           fault;
  logic [NLANE-1:0] b6_now;

  always_comb begin
    stp       = erase_step(fam_q, step_q);
    last_step = (fam_q == FAM_TOGGLE) ? 3'd5 : 3'd2;
    base      = sect_base[cur_q*ADDR_W +: ADDR_W];
    if (st == ST_RD2) begin
      addr_sel = base;
      cmd_sel  = (fam_q == FAM_TOGGLE) ? C_RESET_B : C_RESET_A;
    end else begin
      addr_sel = base + (ADDR_W'(stp.ofs) << OFS_SH);
      cmd_sel  = stp.cmd;
    end
  end

  assign tmr_load = (st == ST_WR) && (step_q == last_step);
  assign tmr_run  = (st == ST_RD0) || (st == ST_RD1) || (st == ST_RD2);

  nes_cmd_lanes #(.PORT_BYTES(PORT_BYTES), .CHIP_BYTES(CHIP_BYTES)) u_lanes (
    .cmd  (cmd_sel),
    .word (lane_word)
  );

  nes_poll_eval #(.PORT_BYTES(PORT_BYTES), .CHIP_BYTES(CHIP_BYTES)) u_eval (
    .fam      (fam_q),
    .rdata    (bus_rdata),
    .prev_b6  (prev_b6),
    .prev_ok  (prev_ok),
    .dev_busy (dev_busy),
    .fail     (fail),
    .fault    (fault),
    .b6_now   (b6_now)
  );

  nes_cycle_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .value   (tmo_q),
    .run     (tmr_run),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      fam_q       <= FAM_STAT;
      cur_q       <= '0;
      last_q      <= '0;
      tmo_q       <= '0;
      step_q      <= '0;
      prev_ok     <= 1'b0;
      prev_b6     <= '0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_we      <= 1'b0;
      bus_re      <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      err_timeout <= 1'b0;
      err_cmdseq  <= 1'b0;
      err_erase   <= 1'b0;
      err_locked  <= 1'b0;
      err_vpp     <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      done   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            err_timeout <= 1'b0;
            err_cmdseq  <= 1'b0;
            err_erase   <= 1'b0;
            err_locked  <= 1'b0;
            err_vpp     <= 1'b0;
            if (first_sect > last_sect) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              err    <= 1'b0;
              busy   <= 1'b1;
              cur_q  <= first_sect;
              last_q <= last_sect;
              fam_q  <= fam_e'(fam_sel);
              tmo_q  <= timeout_cycles;
              st     <= ST_CHK;
            end
          end
        end
        ST_CHK: begin
          step_q <= '0;
          st     <= protect_map[cur_q] ? ST_NEXT : ST_WR;
        end
        ST_WR: begin
          bus_we    <= 1'b1;
          bus_addr  <= addr_sel;
          bus_wdata <= lane_word;
          step_q    <= step_q + 3'd1;
          if (step_q == last_step) begin
            prev_ok <= 1'b0;
            st      <= ST_RD0;
          end
        end
        ST_RD0: begin
          bus_re   <= 1'b1;
          bus_addr <= base;
          st       <= ST_RD1;
        end
        ST_RD1: st <= ST_RD2;
        ST_RD2: begin
          prev_b6 <= b6_now;
          prev_ok <= 1'b1;
          if (!dev_busy) begin
            if (fam_q == FAM_STAT) begin
              bus_we    <= 1'b1;
              bus_addr  <= addr_sel;
              bus_wdata <= lane_word;
              if (fail) begin
                err        <= 1'b1;
                err_cmdseq <= err_cmdseq | fault.seq;
                err_erase  <= err_erase  | fault.ers;
                err_locked <= err_locked | fault.lck;
                err_vpp    <= err_vpp    | fault.vpp;
              end
            end
            st <= ST_NEXT;
          end else if (expired) begin
            bus_we      <= 1'b1;
            bus_addr    <= addr_sel;
            bus_wdata   <= lane_word;
            err         <= 1'b1;
            err_timeout <= 1'b1;
            st          <= ST_NEXT;
          end else begin
            st <= ST_RD0;
          end
        end
        ST_NEXT: begin
          if (cur_q == last_q) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cur_q <= cur_q + SW'(1);
            st    <= ST_CHK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int NSECT      = 8,
  parameter int PORT_BYTES = 2,
  parameter int CHIP_BYTES = 2,
  localparam int SW = $clog2(NSECT),
  localparam int DW = PORT_BYTES * 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             bus_we,
  input logic             bus_re,
  input logic [DW-1:0]    bus_wdata,
  input logic             err_timeout,
  input logic [NSECT-1:0] protect_map,
  input logic [SW-1:0]    cur_q
);
  logic [7:0] top_byte;
  assign top_byte = bus_wdata[CHIP_BYTES*8-1 -: 8];

  // R12: strobes exclusive
  a_r12_no_we_re: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  // R12: single-cycle read strobe
  a_r12_re_single: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);

  // R11: done is a one-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: sectors visited in ascending order
  a_r11_ascending: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cur_q >= $past(cur_q)));

  // R11: bus writes only during a run
  a_r11_we_busy: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> busy);

  // R4: no traffic on a protected sector
  a_r4_no_prot_traffic: assert property (@(posedge clk) disable iff (rst)
    (busy && (bus_we || bus_re)) |-> !protect_map[cur_q]);

  // R8: timeout flag appears with a reset command write
  a_r8_timeout_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> (bus_we && (top_byte == 8'hFF || top_byte == 8'hF0)));
endmodule

bind nor_erase_seq nor_erase_seq_chk #(
  .NSECT(NSECT), .PORT_BYTES(PORT_BYTES), .CHIP_BYTES(CHIP_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .bus_we(bus_we),
  .bus_re(bus_re), .bus_wdata(bus_wdata), .err_timeout(err_timeout),
  .protect_map(protect_map), .cur_q(cur_q)
);

// File: tb/nor_erase_seq_tb.sv
`timescale 1ns/1ps
module nor_erase_seq_tb;
  localparam int NSECT = 8, SW = 3, ADDR_W = 24, TO_W = 16, DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, fam_sel;
  logic [SW-1:0] first_sect, last_sect;
  logic [NSECT-1:0] protect_map;
  logic [NSECT*ADDR_W-1:0] sect_base;
  logic [TO_W-1:0] timeout_cycles;
  logic [ADDR_W-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, busy, done, err;
  logic err_timeout, err_cmdseq, err_erase, err_locked, err_vpp;

  nor_erase_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .first_sect(first_sect),
    .last_sect(last_sect), .protect_map(protect_map), .sect_base(sect_base),
    .fam_sel(fam_sel), .timeout_cycles(timeout_cycles), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_we(bus_we),
    .bus_re(bus_re), .busy(busy), .done(done), .err(err),
    .err_timeout(err_timeout), .err_cmdseq(err_cmdseq), .err_erase(err_erase),
    .err_locked(err_locked), .err_vpp(err_vpp)
  );

  for (genvar i = 0; i < NSECT; i++) begin : g_base
    assign sect_base[i*ADDR_W +: ADDR_W] = ADDR_W'(i) << 16;
  end

  // Device model
  int   busy_cfg = 0;
  int   busy_left = 0;
  int   rd_cnt = 0;
  logic stuck = 1'b0;
  logic [7:0] fin_stat = 8'h00;
  logic tog = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      busy_left <= 0;
    end else begin
      if (bus_we && (bus_wdata[15:8] == 8'hD0 || bus_wdata[15:8] == 8'h30))
        busy_left <= busy_cfg;
      if (bus_re) begin
        rd_cnt <= rd_cnt + 1;
        if (stuck || busy_left > 0) begin
          if (!stuck) busy_left <= busy_left - 1;
          tog <= ~tog;
          bus_rdata <= {(fam_sel ? {1'b0, ~tog, 6'b0} : 8'h00), 8'h00};
        end else begin
          bus_rdata <= {(fam_sel ? 8'h00 : (8'h80 | fin_stat)), 8'h00};
        end
      end
    end
  end

  // Scoreboard
  typedef struct packed { logic [ADDR_W-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t        exp_wr[$];
  logic [5:0] exp_res[$];
  int checks = 0, errors = 0, done_cnt = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_we && bus_re) check(1'b0, "R12", "we and re together", 1, 0);
      if (bus_we) begin
        if (exp_wr.size() == 0) check(1'b0, cur_req, "unexpected write", {bus_addr, bus_wdata}, 0);
        else begin
          wr_t e;
          e = exp_wr.pop_front();
          check({bus_addr, bus_wdata} == {e.a, e.d}, cur_req, "write addr/data",
                {bus_addr, bus_wdata}, {e.a, e.d});
        end
      end
      if (done) begin
        done_cnt++;
        if (exp_res.size() == 0) check(1'b0, cur_req, "unexpected done", 1, 0);
        else begin
          logic [5:0] r;
          r = exp_res.pop_front();
          check({err, err_timeout, err_cmdseq, err_erase, err_locked, err_vpp} == r,
                cur_req, "result flags",
                {err, err_timeout, err_cmdseq, err_erase, err_locked, err_vpp}, r);
          check(!busy, "R11", "busy low at done", busy, 0);
        end
      end
    end
  end

  function automatic void push_wr(input logic [ADDR_W-1:0] a, input logic [7:0] c);
    exp_wr.push_back('{a: a, d: {c, 8'h00}});
  endfunction

  task automatic run(input bit fam, input int f, input int l, input logic [7:0] prot,
                     input int nbusy, input bit stk, input logic [7:0] fs,
                     input int tmo, input string req);
    logic [5:0] res;
    int n0;
    res = 6'b0;
    cur_req = req;
    if (f > l) res = 6'b100000;
    else begin
      for (int s = f; s <= l; s++) begin
        logic [ADDR_W-1:0] b;
        b = ADDR_W'(s) << 16;
        if (prot[s]) continue;
        if (!fam) begin
          push_wr(b, 8'h50); push_wr(b, 8'h20); push_wr(b, 8'hD0);
          push_wr(b, 8'hFF);
          if (stk) res = res | 6'b110000;
          else if (fs[5] | fs[4] | fs[3] | fs[1]) begin
            res[5] = 1'b1;
            if (fs[5] && fs[4]) res[3] = 1'b1;
            if (fs[5] && !fs[4]) res[2] = 1'b1;
            if (fs[1]) res[1] = 1'b1;
            if (fs[3]) res[0] = 1'b1;
          end
        end else begin
          push_wr(b + 24'hAAA, 8'hAA); push_wr(b + 24'h554, 8'h55);
          push_wr(b + 24'hAAA, 8'h80); push_wr(b + 24'hAAA, 8'hAA);
          push_wr(b + 24'h554, 8'h55); push_wr(b, 8'h30);
          if (stk) begin
            push_wr(b, 8'hF0);
            res = res | 6'b110000;
          end
        end
      end
    end
    exp_res.push_back(res);
    @(negedge clk);
    fam_sel = fam; first_sect = SW'(f); last_sect = SW'(l);
    protect_map = prot; busy_cfg = nbusy; stuck = stk; fin_stat = fs;
    timeout_cycles = TO_W'(tmo); rd_cnt = 0;
    n0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (f <= l) check(busy == 1'b1, "R11", "busy after start", busy, 1);
    for (int k = 0; k < 20000; k++) begin
      if (done_cnt != n0) break;
      @(negedge clk); #1;
    end
    check(done_cnt != n0, req, "done seen", done_cnt - n0, 1);
    check(exp_wr.size() == 0, req, "writes left over", exp_wr.size(), 0);
    exp_wr.delete(); exp_res.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; fam_sel = 1'b0; first_sect = '0; last_sect = '0;
    protect_map = '0; timeout_cycles = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, bus_we, bus_re, err, err_timeout, err_cmdseq, err_erase,
           err_locked, err_vpp} == 10'b0, "R1", "reset outputs",
          {busy, done, bus_we, bus_re, err}, 0);

    run(1'b0, 1, 3, 8'h00, 3, 1'b0, 8'h00, 1000, "R2");
    run(1'b0, 2, 2, 8'h00, 5, 1'b0, 8'h00, 1000, "R6");
    check(rd_cnt == 6, "R6", "status reads", rd_cnt, 6);
    run(1'b0, 0, 0, 8'h00, 0, 1'b0, 8'h00, 1000, "R10");
    check(rd_cnt == 1, "R10", "single read when ready", rd_cnt, 1);
    run(1'b0, 0, 4, 8'b0000_1010, 2, 1'b0, 8'h00, 1000, "R4");
    run(1'b1, 2, 4, 8'h00, 4, 1'b0, 8'h00, 1000, "R3");
    run(1'b1, 5, 7, 8'b0100_0000, 0, 1'b0, 8'h00, 1000, "R7");
    run(1'b0, 5, 2, 8'h00, 0, 1'b0, 8'h00, 1000, "R5");
    check(rd_cnt == 0, "R5", "no reads on rejected range", rd_cnt, 0);
    run(1'b0, 6, 7, 8'h00, 0, 1'b1, 8'h00, 25, "R8");
    run(1'b1, 0, 1, 8'h00, 0, 1'b1, 8'h00, 30, "R8");
    run(1'b0, 0, 0, 8'h00, 1, 1'b0, 8'h30, 1000, "R9");
    run(1'b0, 1, 1, 8'h00, 1, 1'b0, 8'h20, 1000, "R9");
    run(1'b0, 2, 2, 8'h00, 1, 1'b0, 8'h02, 1000, "R9");
    run(1'b0, 3, 3, 8'h00, 1, 1'b0, 8'h08, 1000, "R9");
    run(1'b0, 4, 4, 8'h00, 1, 1'b0, 8'h10, 1000, "R9");
    run(1'b0, 3, 6, 8'b0001_0000, 1, 1'b0, 8'h22, 1000, "R11");
    run(1'b0, 0, 7, 8'b1000_0001, 0, 1'b1, 8'h00, 0, "R11");
    run(1'b1, 6, 6, 8'h00, 2, 1'b0, 8'h00, 1000, "R12");

    report();
    $finish;
  end
endmodule